// File: doc/BRIEF.md
# Ring Descriptor Access Sequencer

This block performs the bus-master memory accesses a network controller makes on one transmit or receive ring descriptor. A descriptor is four 16-bit words. Word n sits at the descriptor base plus 2·n bytes. The block accepts a command that either fetches the descriptor or writes status back to it. It then requests the bus and, inside a single bus ownership, issues the word accesses in a fixed order. When the last access completes it releases the bus.

A fetch always reads three words, and the order is non-sequential: word 1, then word 0, then word 2. The fetched words are presented on three output registers named by word index, not by the order in which they were read. A status write-back covers word 1 alone when the descriptor is chained and does not end the packet. In every other case it writes word 1 and then word 3. Each written word carries its own 2-bit byte-lane mask, so only the bytes that changed reach memory.

The block never mixes reads and writes, and never touches two descriptors, within one ownership. An ownership therefore holds three, two or one accesses.

Top module: `desc_seq`

## Requirements
- R1: After reset, busy, bus_req, done, mem_rd and mem_wr are 0 and all three descriptor word outputs are 0.
- R2: A command presented with cmd_valid while the block is idle raises busy and bus_req one cycle later. cmd_valid while busy is ignored and causes no extra access or ownership.
- R3: No memory strobe (mem_rd or mem_wr) is driven unless bus_gnt is high. After a request, the block waits for the grant for as long as it takes.
- R4: A fetch (cmd_write=0) reads word 1, then word 0, then word 2, at base+2, base+0 and base+4 (modulo 2^AW), with mem_be=2'b11 on each read.
- R5: After a fetch, desc_w0, desc_w1 and desc_w2 hold the data returned from base+0, base+2 and base+4 respectively.
- R6: A write-back with cmd_chained=0, or with cmd_eop=1, writes word 1 (cmd_wdata1 at base+2) and then word 3 (cmd_wdata3 at base+6).
- R7: A write-back with cmd_chained=1 and cmd_eop=0 writes word 1 only.
- R8: mem_be during a write equals the mask supplied for that word (bit 0 is the low byte, bit 1 is the high byte). A word whose mask is 2'b00 issues no strobe, takes one cycle, and the sequence continues.
- R9: An access holds its strobe, address and byte enables unchanged until mem_rdy is sampled high, for any number of wait cycles.
- R10: In the cycle after the last access completes, busy and bus_req are 0 and done is high for exactly one cycle.
- R11: mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_write | input | 1 | 0 = fetch descriptor, 1 = status write-back |
| cmd_base | input | AW | Byte address of descriptor word 0 |
| cmd_chained | input | 1 | Descriptor is part of a chain |
| cmd_eop | input | 1 | Descriptor ends the packet |
| cmd_wdata1 | input | 16 | Data for word 1 on write-back |
| cmd_wdata3 | input | 16 | Data for word 3 on write-back |
| cmd_be1 | input | 2 | Byte-lane mask for word 1 |
| cmd_be3 | input | 2 | Byte-lane mask for word 3 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| mem_addr | output | AW | Access byte address |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Byte-lane enables |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdy | input | 1 | Access complete |
| mem_rdata | input | 16 | Read data |
| desc_w0 | output | 16 | Fetched word 0 |
| desc_w1 | output | 16 | Fetched word 1 |
| desc_w2 | output | 16 | Fetched word 2 |

## Verification
Fetches run with and without wait states and grant delay, and at a base near the top of the address space. These runs separate the 1-0-2 access order from a sequential order, and show that each read lands in the output slot for its word index. Write-backs cover every combination of chaining and end-of-packet, which tells the one-word and two-word ownerships apart. Mixed, single-lane and empty byte masks show that the lane enables pass through unchanged and that an empty mask suppresses the strobe without stalling the sequence. A second command raised mid-run confirms that a busy block drops it.

// File: rtl/desc_seq_pkg.sv
package desc_seq_pkg;
  localparam int WORD_W = 16;
  localparam int LANES  = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER} seq_state_t;

  // Descriptor word touched at a given step of the sequence.
  function automatic logic [1:0] word_at_step(input logic wb, input logic [1:0] step);
    if (wb) return (step == 2'd0) ? 2'd1 : 2'd3;
    case (step)
      2'd0:    return 2'd1;
      2'd1:    return 2'd0;
      default: return 2'd2;
    endcase
  endfunction

  // Number of word accesses a command needs.
  function automatic logic [1:0] steps_needed(input logic wb, input logic chained, input logic eop);
    if (!wb) return 2'd3;
    if (chained && !eop) return 2'd1;
    return 2'd2;
  endfunction
endpackage

// File: rtl/desc_step_plan.sv
module desc_step_plan
  import desc_seq_pkg::*;
(
  input  logic       wb,
  input  logic       chained,
  input  logic       eop,
  input  logic [1:0] step,
  output logic [1:0] word_idx,
  output logic       last_step
);
  logic [1:0] n_steps;

  always_comb begin
    n_steps   = steps_needed(wb, chained, eop);
    word_idx  = word_at_step(wb, step);
    last_step = (step == (n_steps - 2'd1));
  end
endmodule

// File: rtl/desc_read_regs.sv
module desc_read_regs
  import desc_seq_pkg::*;
#(
  parameter int SLOTS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] w0,
  output logic [WORD_W-1:0] w1,
  output logic [WORD_W-1:0] w2
);
  logic [WORD_W-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                 slot_q[g] <= '0;
      else if (wr_en && (wr_idx == 2'(g)))        slot_q[g] <= wr_data;
    end
  end

  assign w0 = slot_q[0];
  assign w1 = slot_q[1];
  assign w2 = slot_q[2];

  // A fetch never targets word 3.
  p_slot_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != 2'd3));
endmodule

// File: rtl/desc_seq.sv
module desc_seq
  import desc_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [AW-1:0]     cmd_base,
  input  logic              cmd_chained,
  input  logic              cmd_eop,
  input  logic [15:0]       cmd_wdata1,
  input  logic [15:0]       cmd_wdata3,
  input  logic [1:0]        cmd_be1,
  input  logic [1:0]        cmd_be3,
  output logic              busy,
  output logic              done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [AW-1:0]     mem_addr,
  output logic [15:0]       mem_wdata,
  output logic [1:0]        mem_be,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic              mem_rdy,
  input  logic [15:0]       mem_rdata,
  output logic [15:0]       desc_w0,
  output logic [15:0]       desc_w1,
  output logic [15:0]       desc_w2
);
  localparam logic [LANES-1:0] ALL_LANES = '1;

  seq_state_t         st_q;
  logic [1:0]         step_q;
  logic               wb_q, ch_q, eop_q, done_q;
  logic [AW-1:0]      base_q;
  logic [WORD_W-1:0]  wd1_q, wd3_q;
  logic [LANES-1:0]   be1_q, be3_q;

  // Named internal events
  logic [1:0]         word_idx;
  logic               last_step;
  logic               in_xfer;
  logic [LANES-1:0]   cur_be;
  logic               strobe_on;
  logic               step_adv;
  logic               rd_capture;
  logic               accept;

  desc_step_plan u_plan (
    .wb(wb_q), .chained(ch_q), .eop(eop_q), .step(step_q),
    .word_idx(word_idx), .last_step(last_step)
  );

  assign in_xfer    = (st_q == ST_XFER);
  assign cur_be     = !wb_q ? ALL_LANES : ((word_idx == 2'd1) ? be1_q : be3_q);
  assign strobe_on  = in_xfer && (!wb_q || (cur_be != '0));
  assign step_adv   = in_xfer && (!strobe_on || mem_rdy);
  assign rd_capture = in_xfer && !wb_q && mem_rdy;
  assign accept     = (st_q == ST_IDLE) && cmd_valid;

  assign mem_rd    = strobe_on && !wb_q;
  assign mem_wr    = strobe_on && wb_q;
  assign mem_be    = strobe_on ? cur_be : '0;
  assign mem_addr  = base_q + (AW'(word_idx) << 1);
  assign mem_wdata = !wb_q ? '0 : ((word_idx == 2'd1) ? wd1_q : wd3_q);

  assign busy    = (st_q != ST_IDLE);
  assign bus_req = busy;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      wb_q   <= 1'b0;
      ch_q   <= 1'b0;
      eop_q  <= 1'b0;
      base_q <= '0;
      wd1_q  <= '0;
      wd3_q  <= '0;
      be1_q  <= '0;
      be3_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q   <= ST_REQ;
          wb_q   <= cmd_write;
          ch_q   <= cmd_chained;
          eop_q  <= cmd_eop;
          base_q <= cmd_base;
          wd1_q  <= cmd_wdata1;
          wd3_q  <= cmd_wdata3;
          be1_q  <= cmd_be1;
          be3_q  <= cmd_be3;
        end
        ST_REQ: if (bus_gnt) begin
          st_q   <= ST_XFER;
          step_q <= '0;
        end
        ST_XFER: if (step_adv) begin
          if (last_step) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  desc_read_regs u_rregs (
    .clk(clk), .rst_n(rst_n), .wr_en(rd_capture), .wr_idx(word_idx),
    .wr_data(mem_rdata), .w0(desc_w0), .w1(desc_w1), .w2(desc_w2)
  );

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy);
  p_gnt_before_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> bus_gnt);
  p_wr_be_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_be != 2'b00));
  p_hold_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_rdy) |=>
      ((mem_rd || mem_wr) && $stable(mem_addr) && $stable(mem_be)));
  p_done_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

// File: tb/tb_desc_seq.sv
module tb_desc_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_chained = 1'b0, cmd_eop = 1'b0;
  logic [15:0] cmd_base = '0, cmd_wdata1 = '0, cmd_wdata3 = '0;
  logic [1:0] cmd_be1 = '0, cmd_be3 = '0;
  logic busy, done, bus_req, mem_rd, mem_wr;
  logic bus_gnt = 1'b0, mem_rdy = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0, desc_w0, desc_w1, desc_w2;
  logic [1:0] mem_be;

  always #5 clk = ~clk;

  desc_seq #(.AW(16)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_base(cmd_base), .cmd_chained(cmd_chained), .cmd_eop(cmd_eop),
    .cmd_wdata1(cmd_wdata1), .cmd_wdata3(cmd_wdata3), .cmd_be1(cmd_be1),
    .cmd_be3(cmd_be3), .busy(busy), .done(done), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdy(mem_rdy),
    .mem_rdata(mem_rdata), .desc_w0(desc_w0), .desc_w1(desc_w1), .desc_w2(desc_w2)
  );

  int checks = 0, failures = 0;
  int cur_wait = 0, cur_gdly = 0, wcnt = 0, gcnt = 0;
  int gnt_viol = 0, hold_viol = 0, log_n = 0;
  logic [15:0] start_addr;
  logic [15:0] log_addr [8];
  logic [15:0] log_data [8];
  logic        log_wr   [8];
  logic [1:0]  log_be   [8];

  function automatic logic [15:0] rd_pat(input logic [15:0] a);
    return (a * 16'd3) ^ 16'hC35A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Grant and memory model, driven away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt = 1'b0; gcnt = 0; mem_rdy = 1'b0; wcnt = 0;
    end else begin
      if (bus_req) begin
        if (gcnt >= cur_gdly) bus_gnt = 1'b1; else gcnt++;
      end else begin
        bus_gnt = 1'b0; gcnt = 0;
      end
      if (mem_rd || mem_wr) begin
        mem_rdata = rd_pat(mem_addr);
        if (wcnt == 0) start_addr = mem_addr;
        if (!bus_gnt) gnt_viol++;
        if (wcnt >= cur_wait) begin
          mem_rdy = 1'b1;
          if (mem_addr != start_addr) hold_viol++;
          if (log_n < 8) begin
            log_addr[log_n] = mem_addr; log_wr[log_n] = mem_wr;
            log_data[log_n] = mem_wdata; log_be[log_n] = mem_be;
          end
          log_n++;
          wcnt = 0;
        end else begin
          mem_rdy = 1'b0; wcnt++;
        end
      end else begin
        mem_rdy = 1'b0; wcnt = 0;
      end
    end
  end

  // {write, chained, eop, base, be1, be3, wait, grant delay}
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 16'h1000, 2'b11, 2'b11, 2'd0, 2'd0},
    {1'b0, 1'b1, 1'b0, 16'h2A40, 2'b11, 2'b11, 2'd2, 2'd3},
    {1'b1, 1'b0, 1'b0, 16'h3000, 2'b11, 2'b11, 2'd1, 2'd1},
    {1'b1, 1'b1, 1'b1, 16'h4010, 2'b01, 2'b10, 2'd0, 2'd0},
    {1'b1, 1'b1, 1'b0, 16'h5020, 2'b10, 2'b11, 2'd3, 2'd2},
    {1'b1, 1'b0, 1'b0, 16'h6030, 2'b00, 2'b11, 2'd1, 2'd0},
    {1'b1, 1'b1, 1'b0, 16'h7040, 2'b00, 2'b01, 2'd0, 2'd1},
    {1'b0, 1'b0, 1'b1, 16'hFFFC, 2'b11, 2'b11, 2'd1, 2'd0}
  };

  task automatic run_cmd(input logic [26:0] v, input bit poke);
    logic wb, ch, eop;
    logic [15:0] base;
    logic [1:0] be1, be3;
    logic [15:0] e_addr [4];
    logic [15:0] e_data [4];
    logic [1:0]  e_be   [4];
    int e_n, n;
    string tg;
    {wb, ch, eop, base, be1, be3} = v[26:4];
    cur_wait = int'(v[3:2]); cur_gdly = int'(v[1:0]);
    e_n = 0;
    if (!wb) begin
      e_addr[0] = base + 16'd2; e_addr[1] = base; e_addr[2] = base + 16'd4;
      for (int k = 0; k < 3; k++) begin e_data[k] = 16'h0; e_be[k] = 2'b11; end
      e_n = 3;
    end else begin
      if (be1 != 2'b00) begin
        e_addr[e_n] = base + 16'd2; e_data[e_n] = base ^ 16'h1111; e_be[e_n] = be1; e_n++;
      end
      if ((!ch || eop) && be3 != 2'b00) begin
        e_addr[e_n] = base + 16'd6; e_data[e_n] = base ^ 16'h3333; e_be[e_n] = be3; e_n++;
      end
    end
    tg = !wb ? "R4" : (ch && !eop) ? "R7" : "R6";
    log_n = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wb; cmd_chained = ch; cmd_eop = eop; cmd_base = base;
    cmd_wdata1 = base ^ 16'h1111; cmd_wdata3 = base ^ 16'h3333; cmd_be1 = be1; cmd_be3 = be3;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && bus_req, "R2 accept raises busy/bus_req", {30'd0, busy, bus_req}, 32'd3);
    if (poke) begin
      cmd_valid = 1'b1; cmd_base = base ^ 16'h0F00; cmd_write = ~wb;
    end
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk); n++;
      if (poke && n == 3) cmd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
    chk(done === 1'b1, "R10 done seen", {31'd0, done}, 32'd1);
    chk(!busy && !bus_req, "R10 release with done", {30'd0, busy, bus_req}, 32'd0);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", {31'd0, done}, 32'd0);
    chk(!busy, "R2 no extra ownership", {31'd0, busy}, 32'd0);
    chk(log_n == e_n, {tg, " access count"}, log_n, e_n);
    for (int k = 0; k < e_n && k < log_n; k++) begin
      chk(log_addr[k] == e_addr[k], {tg, " address order"}, log_addr[k], e_addr[k]);
      chk(log_wr[k] == wb, "R11 access kind", {31'd0, log_wr[k]}, {31'd0, wb});
      chk(log_be[k] == e_be[k], "R8 byte lanes", log_be[k], e_be[k]);
      if (wb) chk(log_data[k] == e_data[k], {tg, " write data"}, log_data[k], e_data[k]);
    end
    if (!wb) begin
      chk(desc_w0 == rd_pat(base), "R5 word 0 slot", desc_w0, rd_pat(base));
      chk(desc_w1 == rd_pat(base + 16'd2), "R5 word 1 slot", desc_w1, rd_pat(base + 16'd2));
      chk(desc_w2 == rd_pat(base + 16'd4), "R5 word 2 slot", desc_w2, rd_pat(base + 16'd4));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_req && !done, "R1 reset control", {29'd0, busy, bus_req, done}, 32'd0);
    chk(!mem_rd && !mem_wr, "R1 reset strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    chk(desc_w0 == 0 && desc_w1 == 0 && desc_w2 == 0, "R1 reset words", desc_w0 | desc_w1 | desc_w2, 32'd0);
    for (int i = 0; i < NV; i++) run_cmd(VEC[i], 1'b0);
    // A command raised while busy is ignored (R2).
    run_cmd({1'b0, 1'b0, 1'b0, 16'h8800, 2'b11, 2'b11, 2'd1, 2'd2}, 1'b1);
    run_cmd({1'b1, 1'b1, 1'b0, 16'h9900, 2'b11, 2'b11, 2'd2, 2'd0}, 1'b1);
    chk(gnt_viol == 0, "R3 strobe only under grant", gnt_viol, 32'd0);
    chk(hold_viol == 0, "R9 address held in wait", hold_viol, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule